// File: doc/BRIEF.md
# Hall-Interval Capture Timer

This block is a 16-bit up-counter that stamps the time of edges seen on one of four input lines. In a brushless motor controller it is pointed at a Hall sensor line so that software can read the counter value at each commutation and work out the interval between Hall transitions. The counter advances on count-enable strobes. Each strobe comes either from a free-running divider of the system clock (divide by 2 up to 128) or from the rising edges of a PWM output signal.

Software controls the block through a small byte-wide register port. It can switch the counter on or off, hold it with a separate pause control, pick the count source, pick which of the three Hall lines or the external pin is watched, and choose which edges are captured. When a qualifying edge arrives on the watched line, after a two-flop synchronizer, the current count is copied into a capture register and a sticky flag is raised. If that flag is still set when another capture happens, an overrun flag is raised as well. When the counter wraps, an overflow flag is raised.

Top module: `hall_capture_timer`

## Requirements
- R1: After reset every readable location reads 0: control (address 0), edge control (address 1), status (address 2), capture low/high (addresses 3/4) and count low/high (addresses 5/6).
- R2: Address 0 holds pause in bit 7, count-source select in bits 6:4, on in bit 3 and watched-line select in bits 1:0. Bit 2 always reads 0. Address 1 holds the edge mode in bits 7:6, and its other bits read 0.
- R3: When a write changes the on bit from 0 to 1, the count is cleared to 0 at that write. While the on bit is 0 the count keeps its value.
- R4: While pause is 1 the count holds. When pause is cleared, counting continues from the held value.
- R5: Count-source codes 1 to 7 select one strobe every 2^code system clocks. Over any window of k*2^code clocks with the counter running, the count rises by exactly k.
- R6: Count-source code 0 advances the count once per rising edge of pwm_out, however long pwm_out stays high.
- R7: Line select 0 watches hall_a, 1 watches hall_b, 2 watches hall_c and 3 watches cap_pin. Edges on lines that are not selected have no effect.
- R8: Edge mode 0 captures nothing, 1 captures rising edges, 2 captures falling edges and 3 captures both.
- R9: A capture stores the count held on the cycle the synchronized edge is detected. Capture low (address 3) and high (address 4) are readable from 3 clocks after the input changes.
- R10: Status bit 0 is a sticky capture flag. Status bit 1 (overrun) is set when a capture occurs while bit 0 is already set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: The count wraps from 0xFFFF to 0x0000, and the wrap sets sticky status bit 2.
- R12: While the on bit is 0, no capture occurs and the capture register and capture flag keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| pwm_out | input | 1 | PWM signal used as count source for code 0 |
| hall_a | input | 1 | Hall line A |
| hall_b | input | 1 | Hall line B |
| hall_c | input | 1 | Hall line C |
| cap_pin | input | 1 | External capture input |

## Verification
Every divide code is run over a window that is an exact multiple of its period. A wrong tap, or an extra or missing strobe, therefore shows up as a count error, whatever phase the divider has. The PWM source gets both short pulses and a long high level, which separates edge counting from level counting. Capture is tried with the counter paused at known values. Random line levels, random line selection, random edge modes and a disturbing toggle on a non-selected line together separate the mux from the edge qualification. Directed runs cover capture while off, the overrun sequence, the clear-on-enable behaviour and a full 16-bit wrap.

// File: rtl/captm_pkg.sv
// Package: shared widths, register addresses and edge-mode encoding for the
// Hall-interval capture timer. Assumes an 8-bit register port.
package captm_pkg;
    localparam int CNT_W       = 16;
    localparam int DIV_STAGES  = 7;
    localparam int SEL_W       = $clog2(DIV_STAGES + 1);
    localparam int NUM_LINES   = 4;
    localparam int LINE_SEL_W  = $clog2(NUM_LINES);
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_EDGE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd6;

    localparam int ST_CAP  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_WRAP = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;
endpackage

// File: rtl/cap_prescaler.sv
// Module: cap_prescaler
// Produces a single-cycle count strobe. Code 0 gives a strobe on every rising
// edge of the PWM input. Code n (1..DIV_STAGES) gives one strobe every 2^n
// clocks from a divider that runs freely from reset. Assumes the PWM input is
// already synchronous to clk.
module cap_prescaler
    import captm_pkg::*;
#(
    parameter int STAGES = DIV_STAGES,
    localparam int SW = $clog2(STAGES + 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] clk_sel_i,
    input  logic          pwm_i,
    output logic          tick_o
);
    logic [STAGES-1:0] div_q;
    logic              pwm_q;
    logic [STAGES:0]   taps;

    // Free-running divider and PWM history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            div_q <= div_q + 1'b1;
            pwm_q <= pwm_i;
        end
    end

    // Tap 0: PWM rising-edge strobe.
    always_comb taps[0] = pwm_i & ~pwm_q;

    genvar n;
    generate
        for (n = 1; n <= STAGES; n++) begin : g_tap
            // Tap n: strobe when the low n divider bits are all ones.
            always_comb taps[n] = &div_q[n-1:0];
        end
    endgenerate

    // Select the strobe named by the clock-select code.
    always_comb tick_o = taps[clk_sel_i];

    // R5: divide-by-2 strobes never appear on consecutive cycles.
    p_div2_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_i == SW'(1) && tick_o) |=> (clk_sel_i != SW'(1) || !tick_o));
    // R6: a PWM level held high yields no second strobe.
    p_pwm_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_i == '0 && tick_o && pwm_i) |=> (clk_sel_i != '0 || !tick_o));
endmodule

// File: rtl/cap_input_edge.sv
// Module: cap_input_edge
// Picks one of the input lines, passes it through a two-flop synchronizer and
// flags the edges that the edge mode qualifies. Assumes the lines are
// asynchronous and slower than clk.
module cap_input_edge
    import captm_pkg::*;
#(
    parameter int LINES = NUM_LINES,
    localparam int LW = $clog2(LINES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    input  logic [LW-1:0]    line_sel_i,
    input  edge_mode_e       mode_i,
    output logic             evt_o
);
    logic sel_line;
    logic sync1_q, sync2_q, hist_q;
    logic rise, fall;

    // Multiplex the watched line.
    always_comb sel_line = lines_i[line_sel_i];

    // Synchronizer pair plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            hist_q  <= 1'b0;
        end else begin
            sync1_q <= sel_line;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
        end
    end

    // Raw edges on the synchronized line.
    always_comb begin
        rise = sync2_q & ~hist_q;
        fall = ~sync2_q & hist_q;
    end

    // Qualify edges by the programmed mode.
    always_comb begin
        unique case (mode_i)
            EDGE_RISE: evt_o = rise;
            EDGE_FALL: evt_o = fall;
            EDGE_BOTH: evt_o = rise | fall;
            default:   evt_o = 1'b0;
        endcase
    end

    // R8: mode 0 never produces an event.
    p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_NONE) |-> !evt_o);
endmodule

// File: rtl/cap_counter.sv
// Module: cap_counter
// Up-counter that advances on strobes while on and not paused. It clears on the
// clear pulse that an off-to-on write produces, and it reports a wrap pulse.
module cap_counter
    import captm_pkg::*;
#(
    parameter int W = CNT_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         on_i,
    input  logic         pause_i,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;
    logic         adv;

    // Advance condition and wrap detection.
    always_comb begin
        adv    = on_i & ~pause_i & tick_i;
        wrap_o = adv & (&cnt_q);
    end

    // Count register: clear wins over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (adv)    cnt_q <= cnt_q + 1'b1;
    end

    always_comb cnt_o = cnt_q;

    // R3: an enabling write leaves the count at zero.
    p_clear_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    // R3: while off the count keeps its residue.
    p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
    // R4: pause holds the count.
    p_pause_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
    // R11: a wrap lands on zero.
    p_wrap_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cap_regs.sv
// Module: cap_regs
// Register file: control fields, the capture latch and the sticky status
// flags with write-one-to-clear. Reads are combinational from the address.
// A flag being set wins over a clear in the same cycle.
module cap_regs
    import captm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic                   wrap_i,
    input  logic                   cap_evt_i,
    output logic                   on_o,
    output logic                   pause_o,
    output logic                   clr_o,
    output logic [SEL_W-1:0]       clk_sel_o,
    output logic [LINE_SEL_W-1:0]  line_sel_o,
    output edge_mode_e             mode_o
);
    logic                  pause_q, on_q;
    logic [SEL_W-1:0]      clk_sel_q;
    logic [LINE_SEL_W-1:0] line_sel_q;
    edge_mode_e            mode_q;
    logic [CNT_W-1:0]      cap_q;
    logic                  capf_q, ovr_q, wrapf_q;
    logic                  wr_ctrl, wr_edge;
    logic [2:0]            w1c;
    logic                  take;

    // Write decode, enable-edge clear pulse and capture qualification.
    always_comb begin
        wr_ctrl = wr_i && (addr_i == A_CTRL);
        wr_edge = wr_i && (addr_i == A_EDGE);
        w1c     = (wr_i && (addr_i == A_STAT)) ? wdata_i[2:0] : 3'b000;
        clr_o   = wr_ctrl && wdata_i[3] && !on_q;
        take    = cap_evt_i && on_q;
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_q    <= 1'b0;
            clk_sel_q  <= '0;
            on_q       <= 1'b0;
            line_sel_q <= '0;
            mode_q     <= EDGE_NONE;
        end else begin
            if (wr_ctrl) begin
                pause_q    <= wdata_i[7];
                clk_sel_q  <= wdata_i[4 +: SEL_W];
                on_q       <= wdata_i[3];
                line_sel_q <= wdata_i[0 +: LINE_SEL_W];
            end
            if (wr_edge) mode_q <= edge_mode_e'(wdata_i[7:6]);
        end
    end

    // Capture latch.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (take) cap_q <= cnt_i;
    end

    // Sticky status flags, set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capf_q  <= 1'b0;
            ovr_q   <= 1'b0;
            wrapf_q <= 1'b0;
        end else begin
            if (take)              capf_q <= 1'b1;
            else if (w1c[ST_CAP])  capf_q <= 1'b0;
            if (take && capf_q)    ovr_q <= 1'b1;
            else if (w1c[ST_OVR])  ovr_q <= 1'b0;
            if (wrap_i)            wrapf_q <= 1'b1;
            else if (w1c[ST_WRAP]) wrapf_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = {pause_q, clk_sel_q, on_q, 1'b0, line_sel_q};
            A_EDGE:   rdata_o = {mode_q, 6'b0};
            A_STAT:   rdata_o = {5'b0, wrapf_q, ovr_q, capf_q};
            A_CAP_LO: rdata_o = cap_q[7:0];
            A_CAP_HI: rdata_o = cap_q[CNT_W-1:8];
            A_CNT_LO: rdata_o = cnt_i[7:0];
            A_CNT_HI: rdata_o = cnt_i[CNT_W-1:8];
            default:  rdata_o = '0;
        endcase
    end

    // Field outputs.
    always_comb begin
        on_o       = on_q;
        pause_o    = pause_q;
        clk_sel_o  = clk_sel_q;
        line_sel_o = line_sel_q;
        mode_o     = mode_q;
    end

    // R9: the latch holds the count present at the event.
    p_cap_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_i && on_q) |=> (cap_q == $past(cnt_i)));
    // R12: while off an event leaves the latch and the flag alone.
    p_off_nocap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_i && !on_q && !w1c[ST_CAP]) |=> ($stable(cap_q) && $stable(capf_q)));
    // R10: a capture onto a set flag raises overrun.
    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_i && on_q && capf_q) |=> ovr_q);
    // R11: a wrap raises the sticky wrap flag.
    p_wrap_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> wrapf_q);
endmodule

// File: rtl/hall_capture_timer.sv
// Module: hall_capture_timer (top)
// Joins the prescaler, input edge detector, counter and register file.
// Assumes all inputs besides the Hall lines and cap_pin are synchronous to clk.
module hall_capture_timer
    import captm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pwm_out,
    input  logic              hall_a,
    input  logic              hall_b,
    input  logic              hall_c,
    input  logic              cap_pin
);
    logic                  on, pause, clr, tick, wrap, evt;
    logic [SEL_W-1:0]      clk_sel;
    logic [LINE_SEL_W-1:0] line_sel;
    edge_mode_e            mode;
    logic [CNT_W-1:0]      cnt;
    logic [NUM_LINES-1:0]  lines;

    // Line vector in select-code order.
    always_comb lines = {cap_pin, hall_c, hall_b, hall_a};

    cap_prescaler #(.STAGES(DIV_STAGES)) u_presc (
        .clk(clk), .rst_n(rst_n), .clk_sel_i(clk_sel),
        .pwm_i(pwm_out), .tick_o(tick)
    );

    cap_input_edge #(.LINES(NUM_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines_i(lines),
        .line_sel_i(line_sel), .mode_i(mode), .evt_o(evt)
    );

    cap_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .on_i(on), .pause_i(pause),
        .clr_i(clr), .tick_i(tick), .cnt_o(cnt), .wrap_o(wrap)
    );

    cap_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .cnt_i(cnt),
        .wrap_i(wrap), .cap_evt_i(evt), .on_o(on), .pause_o(pause),
        .clr_o(clr), .clk_sel_o(clk_sel), .line_sel_o(line_sel),
        .mode_o(mode)
    );
endmodule

// File: tb/hall_capture_timer_tb_top.sv
module hall_capture_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pwm_out = 1'b0;
    logic [3:0] ln = '0;
    int vectors = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hall_capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
        .hall_a(ln[0]), .hall_b(ln[1]), .hall_c(ln[2]), .cap_pin(ln[3])
    );

    function automatic bit edge_hit(input bit [1:0] m, input bit o, input bit n);
        bit r = !o && n;
        bit f = o && !n;
        case (m)
            2'd1: return r;
            2'd2: return f;
            2'd3: return r | f;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] ctrl_word(input bit p, input bit [2:0] cs,
                                             input bit on, input bit [1:0] ls);
        return {p, cs, on, 1'b0, ls};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic gap(input int d);  // makes the next write land d edges later
        repeat (d - 1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v, cbase, cv;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R1 reset", d, 8'h00);
        end

        // R2: layout, reserved bit, edge-control bits
        wr(3'd0, 8'hB7);
        rd(3'd0, d); chk("R2 ctrl0 layout", d, 8'hB3);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); chk("R2 edge ctrl", d, 8'hC0);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);

        // R5: every divide code, 5 strobes per window
        for (int n = 1; n <= 7; n++) begin
            wr(3'd0, 8'h00);
            wr(3'd0, ctrl_word(0, 3'(n), 1, 0));
            gap(5 * (1 << n));
            wr(3'd0, ctrl_word(1, 3'(n), 1, 0));
            rd16(3'd5, v); chk($sformatf("R5 divide code %0d", n), v, 16'd5);
        end

        // R3: off keeps residue; enabling clears
        wr(3'd0, 8'h00);
        repeat (50) @(negedge clk);
        rd16(3'd5, v); chk("R3 off keeps count", v, 16'd5);
        wr(3'd0, ctrl_word(0, 3'd1, 1, 0));
        gap(2);
        wr(3'd0, ctrl_word(1, 3'd1, 1, 0));
        rd16(3'd5, v); chk("R3 enable clears", v, 16'd1);

        // R4: pause hold and resume from held value
        repeat (40) @(negedge clk);
        rd16(3'd5, v); chk("R4 paused holds", v, 16'd1);
        wr(3'd0, ctrl_word(0, 3'd1, 1, 0));
        gap(10);
        wr(3'd0, ctrl_word(1, 3'd1, 1, 0));
        rd16(3'd5, v); chk("R4 resume", v, 16'd6);

        // R6: PWM source counts rising edges only
        wr(3'd0, 8'h00);
        wr(3'd0, ctrl_word(0, 3'd0, 1, 0));
        for (int p = 0; p < 7; p++) begin
            pwm_out = 1'b1; @(negedge clk);
            pwm_out = 1'b0; repeat (2) @(negedge clk);
        end
        pwm_out = 1'b1; repeat (10) @(negedge clk);
        pwm_out = 1'b0; repeat (2) @(negedge clk);
        wr(3'd0, ctrl_word(1, 3'd0, 1, 0));
        rd16(3'd5, v); chk("R6 pwm edges", v, 16'd8);

        // R8/R9: rising capture on hall_a at count 8
        wr(3'd1, 8'h40);
        ln[0] = 1'b1; repeat (4) @(negedge clk);
        rd(3'd2, d); chk("R10 flag set", d, 8'h01);
        rd16(3'd3, v); chk("R9 captured value", v, 16'd8);
        wr(3'd2, 8'h07);
        rd(3'd2, d); chk("R10 w1c clear", d, 8'h00);
        ln[0] = 1'b0; repeat (4) @(negedge clk);
        rd(3'd2, d); chk("R8 falling ignored in rise mode", d, 8'h00);

        // R12: off blocks capture
        wr(3'd0, ctrl_word(1, 3'd0, 0, 0));
        ln[0] = 1'b1; repeat (4) @(negedge clk);
        rd(3'd2, d); chk("R12 no flag while off", d, 8'h00);
        rd16(3'd3, v); chk("R12 latch kept while off", v, 16'd8);
        ln[0] = 1'b0; repeat (4) @(negedge clk);

        // R10: overrun sequence at count 0
        wr(3'd0, ctrl_word(1, 3'd0, 1, 0));
        ln[0] = 1'b1; repeat (4) @(negedge clk);
        rd16(3'd3, v); chk("R3 count cleared then captured", v, 16'd0);
        wr(3'd1, 8'hC0);
        ln[0] = 1'b0; repeat (4) @(negedge clk);
        rd(3'd2, d); chk("R10 overrun", d, 8'h03);
        wr(3'd2, 8'h01);
        rd(3'd2, d); chk("R10 partial clear", d, 8'h02);
        wr(3'd2, 8'h02);
        rd(3'd2, d); chk("R10 overrun clear", d, 8'h00);

        // R7/R8/R9: random selection, levels and modes on a paused counter
        for (int it = 0; it < 40; it++) begin
            bit [1:0] src = 2'($urandom_range(0, 3));
            bit [1:0] md  = 2'($urandom_range(0, 3));
            bit [1:0] oth = 2'(src + 2'($urandom_range(1, 3)));
            bit       old;
            wr(3'd1, 8'h00);
            wr(3'd0, ctrl_word(0, 3'd1, 1, src));
            repeat ($urandom_range(1, 60)) @(negedge clk);
            wr(3'd0, ctrl_word(1, 3'd1, 1, src));
            ln = 4'($urandom_range(0, 15));
            repeat (4) @(negedge clk);
            wr(3'd2, 8'h07);
            wr(3'd1, {md, 6'b0});
            rd16(3'd3, cbase);
            rd16(3'd5, cv);
            old = ln[src];
            ln[src] = ~ln[src];
            ln[oth] = ~ln[oth];
            repeat (4) @(negedge clk);
            rd(3'd2, d);
            chk($sformatf("R7 R8 flag src=%0d mode=%0d", src, md), d[0],
                edge_hit(md, old, ~old));
            rd16(3'd3, v);
            chk("R9 random capture value", v, edge_hit(md, old, ~old) ? cv : cbase);
        end

        // R11: full wrap with divide by 2
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h07);
        wr(3'd0, ctrl_word(0, 3'd1, 1, 0));
        gap(131072);
        wr(3'd0, ctrl_word(1, 3'd1, 1, 0));
        rd16(3'd5, v); chk("R11 wrapped count", v, 16'd0);
        rd(3'd2, d); chk("R11 wrap flag", d, 8'h04);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule